// File: doc/BRIEF.md
# Navigation Frame Symbol Sequencer

This block builds the symbol stream of one 12-second navigation frame, 6000 symbols long, and then starts the next frame. Each frame opens with a fixed 68-symbol synchronisation word that is not encoded. Four subframes follow, each from its own upstream encoder. The block emits exactly one symbol for each 2 ms primary-code epoch strobe, so symbol boundaries always fall on code period boundaries.

Subframe symbols arrive through four ready/valid ports. The block offers ready on one port only, in the cycle of a strobe, and takes the symbol in that same cycle. Each symbol leaves as a two-bit signed BPSK value with a valid flag. A section index names the part of the frame that is being sent. A one-cycle frame-start pulse marks the first sync symbol, so the code generator can align its 12-second tertiary epoch with the frame.

If an upstream source has nothing ready when its symbol is due, the block sends a filler symbol and latches an underrun flag. The frame keeps its length.

Top module: `frame_symbol_seq`

## Requirements
- R1: After reset, symValid, frameStart and underrun are 0, sectionIdx is 0 and symOut is 0.
- R2: symValid is high for exactly one cycle, in the cycle after each cycle where epochStb is high, and is low at all other times.
- R3: The first 68 symbols of every frame carry the sync word 0xCC63F74536F49E04A, most significant bit first.
- R4: sectionIdx is 0 for the 68 sync symbols, then 1 for 52 symbols, 2 for 2400 symbols, 3 for 1740 symbols and 4 for 1740 symbols. After these 6000 symbols the sequence starts again at section 0.
- R5: srcReady bit k is high only in a cycle where epochStb is high and the next symbol belongs to section k+1. At most one ready bit is high at a time. srcSym bit k is taken in that cycle.
- R6: A logic 1 symbol is output as -1 (2'b11) and a logic 0 symbol as +1 (2'b01).
- R7: frameStart is high for one cycle together with the first sync symbol of each frame, and at no other time.
- R8: If srcValid bit k is low when a symbol of section k+1 is due, the block outputs +1. It sets underrun, which then stays high until reset, and still advances the symbol count.
- R9: Cycles without epochStb do not advance the sequence. The next symbol after any idle gap is the one that was due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| epochStb | input | 1 | One-cycle strobe per primary-code epoch |
| srcValid | input | 4 | Valid flag of each subframe source (bit k = subframe k+1) |
| srcSym | input | 4 | Symbol bit of each subframe source |
| srcReady | output | 4 | Ready to each source; a symbol is taken when ready is high |
| symOut | output | 2 | Signed BPSK symbol, +1 or -1 |
| symValid | output | 1 | symOut holds a new symbol |
| frameStart | output | 1 | Pulse with the first sync symbol of a frame |
| sectionIdx | output | 3 | 0 = sync word, 1 to 4 = subframe number |
| underrun | output | 1 | Sticky flag: a source was not valid when its symbol was due |

## Verification
The assertions assume that epochStb is a single-cycle pulse and that reset is held low for at least one clock edge before the first strobe. The ready and valid checks also assume that a source's symbol is sampled only in the strobe cycle. The stimulus follows this: every strobe is one cycle wide with at least one idle cycle after it, and source inputs change only at falling edges. The stimulus also includes long idle gaps and a frame wrap, to test the epoch timing.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int NUM_SRC = 4;
  localparam int SEC_W   = 3;

  // Control-to-datapath strobes for one epoch
  typedef struct packed {
    logic             fire;        // epoch strobe this cycle
    logic             frameFirst;  // next symbol opens a frame
    logic             syncBit;     // current sync word bit
    logic [SEC_W-1:0] sec;         // section of the next symbol
  } seqStrobe_t;
endpackage

// File: rtl/fss_ctrl.sv
module fss_ctrl
  import fss_pkg::*;
#(
  parameter int SYNC_LEN = 68,
  parameter logic [SYNC_LEN-1:0] SYNC_WORD = 68'hCC63F74536F49E04A,
  parameter int SF1_LEN = 52,
  parameter int SF2_LEN = 2400,
  parameter int SF3_LEN = 1740,
  parameter int SF4_LEN = 1740
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       epochStb,
  output seqStrobe_t strb
);
  localparam int FRAME_LEN = SYNC_LEN + SF1_LEN + SF2_LEN + SF3_LEN + SF4_LEN;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(NUM_SRC);

  logic [POS_W-1:0]    posCnt;
  logic [SEC_W-1:0]    secIdx;
  logic [SYNC_LEN-1:0] syncRot;

  function automatic logic [POS_W-1:0] lastPos(input logic [SEC_W-1:0] s);
    case (s)
      3'd0:    lastPos = POS_W'(SYNC_LEN - 1);
      3'd1:    lastPos = POS_W'(SF1_LEN - 1);
      3'd2:    lastPos = POS_W'(SF2_LEN - 1);
      3'd3:    lastPos = POS_W'(SF3_LEN - 1);
      default: lastPos = POS_W'(SF4_LEN - 1);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCnt  <= '0;
      secIdx  <= '0;
      syncRot <= SYNC_WORD;
    end else if (epochStb) begin
      if (secIdx == '0)
        syncRot <= {syncRot[SYNC_LEN-2:0], syncRot[SYNC_LEN-1]};
      if (posCnt == lastPos(secIdx)) begin
        posCnt <= '0;
        secIdx <= (secIdx == LAST_SEC) ? '0 : secIdx + 1'b1;
      end else begin
        posCnt <= posCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.fire       = epochStb;
    strb.frameFirst = (secIdx == '0) && (posCnt == '0);
    strb.syncBit    = syncRot[SYNC_LEN-1];
    strb.sec        = secIdx;
  end
endmodule

// File: rtl/fss_dpath.sv
module fss_dpath
  import fss_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic [NUM_SRC-1:0] srcValid,
  input  logic [NUM_SRC-1:0] srcSym,
  output logic [NUM_SRC-1:0] srcReady,
  output logic signed [1:0]  symOut,
  output logic               symValid,
  output logic               frameStart,
  output logic [SEC_W-1:0]   sectionIdx,
  output logic               underrun
);
  localparam int SEL_W = $clog2(NUM_SRC);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_ready
    assign srcReady[k] = strb.fire && (strb.sec == SEC_W'(k + 1));
  end

  logic [SEL_W-1:0] srcSel;
  logic             haveSym;
  logic             symBit;

  always_comb begin
    srcSel = SEL_W'(strb.sec - 1'b1);
    if (strb.sec == '0) begin
      haveSym = 1'b1;
      symBit  = strb.syncBit;
    end else begin
      haveSym = srcValid[srcSel];
      symBit  = srcValid[srcSel] & srcSym[srcSel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      symOut     <= '0;
      symValid   <= 1'b0;
      frameStart <= 1'b0;
      sectionIdx <= '0;
      underrun   <= 1'b0;
    end else begin
      symValid   <= strb.fire;
      frameStart <= strb.fire && strb.frameFirst;
      if (strb.fire) begin
        symOut     <= symBit ? 2'sb11 : 2'sb01;
        sectionIdx <= strb.sec;
        if (!haveSym) underrun <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_symbol_seq.sv
module frame_symbol_seq
  import fss_pkg::*;
#(
  parameter int SYNC_LEN = 68,
  parameter logic [SYNC_LEN-1:0] SYNC_WORD = 68'hCC63F74536F49E04A,
  parameter int SF1_LEN = 52,
  parameter int SF2_LEN = 2400,
  parameter int SF3_LEN = 1740,
  parameter int SF4_LEN = 1740
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               epochStb,
  input  logic [NUM_SRC-1:0] srcValid,
  input  logic [NUM_SRC-1:0] srcSym,
  output logic [NUM_SRC-1:0] srcReady,
  output logic signed [1:0]  symOut,
  output logic               symValid,
  output logic               frameStart,
  output logic [SEC_W-1:0]   sectionIdx,
  output logic               underrun
);
  seqStrobe_t strb;

  fss_ctrl #(
    .SYNC_LEN(SYNC_LEN), .SYNC_WORD(SYNC_WORD),
    .SF1_LEN(SF1_LEN), .SF2_LEN(SF2_LEN), .SF3_LEN(SF3_LEN), .SF4_LEN(SF4_LEN)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .epochStb(epochStb), .strb(strb)
  );

  fss_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .srcValid(srcValid), .srcSym(srcSym), .srcReady(srcReady),
    .symOut(symOut), .symValid(symValid), .frameStart(frameStart),
    .sectionIdx(sectionIdx), .underrun(underrun)
  );
endmodule

// File: rtl/fss_checker.sv
module fss_checker
  import fss_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               epochStb,
  input logic [NUM_SRC-1:0] srcReady,
  input logic signed [1:0]  symOut,
  input logic               symValid,
  input logic               frameStart,
  input logic [SEC_W-1:0]   sectionIdx,
  input logic               underrun
);
  // R2
  sym_follows_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    epochStb |=> symValid);
  // R2
  no_sym_without_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    !epochStb |=> !symValid);
  // R5
  ready_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcReady));
  // R5
  ready_only_on_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcReady != '0) |-> epochStb);
  // R6
  bpsk_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    symValid |-> (symOut == 2'sb01 || symOut == 2'sb11));
  // R7
  start_in_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (symValid && sectionIdx == '0));
  // R4
  section_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    sectionIdx <= SEC_W'(NUM_SRC));
  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun);
endmodule

bind frame_symbol_seq fss_checker chk_i (.*);

// File: tb/frame_symbol_seq_tb_top.sv
module frame_symbol_seq_tb_top;
  localparam int FRAME_LEN = 6000;
  localparam logic [67:0] SYNC = 68'hCC63F74536F49E04A;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       epochStb = 1'b0;
  logic [3:0] srcValid = '0;
  logic [3:0] srcSym = '0;
  logic [3:0] srcReady;
  logic signed [1:0] symOut;
  logic       symValid, frameStart, underrun;
  logic [2:0] sectionIdx;

  int testCnt = 0;
  int failCnt = 0;
  int symIdx = 0;
  bit expUnder = 1'b0;

  always #2.5 clk = ~clk;

  frame_symbol_seq dut_i (
    .clk(clk), .rstN(rstN), .epochStb(epochStb),
    .srcValid(srcValid), .srcSym(srcSym), .srcReady(srcReady),
    .symOut(symOut), .symValid(symValid), .frameStart(frameStart),
    .sectionIdx(sectionIdx), .underrun(underrun)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int secOf(input int i);
    if (i < 68) return 0;
    if (i < 120) return 1;
    if (i < 2520) return 2;
    if (i < 4260) return 3;
    return 4;
  endfunction

  // One epoch: drive at negedge, check ready, check outputs one negedge later
  task automatic stepSym(input bit vld, input bit val);
    int sec = secOf(symIdx);
    int expBit;
    @(negedge clk);
    epochStb = 1'b1;
    srcValid = vld ? 4'hF : 4'h0;
    srcSym   = val ? 4'hF : 4'h0;
    #1;
    check("R5", "srcReady", int'(srcReady), sec == 0 ? 0 : (1 << (sec - 1)));
    @(negedge clk);
    epochStb = 1'b0;
    if (sec == 0) expBit = int'(SYNC[67 - symIdx]);
    else expBit = vld ? int'(val) : 0;
    if (sec != 0 && !vld) expUnder = 1'b1;
    check("R2", "symValid", int'(symValid), 1);
    check(sec == 0 ? "R3" : "R6", "symOut", int'(symOut), expBit ? -1 : 1);
    check("R4", "sectionIdx", int'(sectionIdx), sec);
    check("R7", "frameStart", int'(frameStart), symIdx == 0 ? 1 : 0);
    check("R8", "underrun", int'(underrun), int'(expUnder));
    symIdx = (symIdx + 1) % FRAME_LEN;
  endtask

  task automatic test_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "symValid", int'(symValid), 0);
    check("R1", "frameStart", int'(frameStart), 0);
    check("R1", "underrun", int'(underrun), 0);
    check("R1", "sectionIdx", int'(sectionIdx), 0);
    check("R1", "symOut", int'(symOut), 0);
    rstN = 1'b1;
  endtask

  task automatic test_sync();
    for (int i = 0; i < 68; i++) stepSym(1'b1, i[0]);  // R3
  endtask

  task automatic test_subframes();
    for (int i = 68; i < FRAME_LEN; i++) stepSym(1'b1, i[0] ^ i[3] ^ i[6]);  // R4 R6
  endtask

  task automatic test_idle();
    // R9: no strobes, nothing emitted
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      check("R9", "symValid idle", int'(symValid), 0);
      check("R9", "frameStart idle", int'(frameStart), 0);
    end
  endtask

  task automatic test_wrap();
    // R7: next frame opens with frameStart and sync word
    test_sync();
    test_idle();
    for (int i = 68; i < 130; i++) stepSym(1'b1, i[1]);
  endtask

  task automatic test_underrun();
    // R8: missing source symbol -> +1, sticky flag, frame length kept
    for (int i = 0; i < 4; i++) stepSym(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) stepSym(1'b1, 1'b1);
    while (symIdx != 0) stepSym(1'b1, symIdx[2]);
    stepSym(1'b1, 1'b0);
  endtask

  initial begin
    #900us;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    test_reset();
    test_sync();
    test_idle();
    test_subframes();
    test_wrap();
    test_underrun();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule